// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Power-Domain Switches

This block is an always-on state machine. It moves a chip between a running state and four low-power states. It drives the control bits that the clock and power network obey:

- a CPU clock enable;
- a PLL enable;
- a global clock freeze;
- a main-supply enable;
- an internal reset;
- one switch enable for each independently powered domain (six by default).

Software asks for a low-power state with a single-cycle request carrying a mode code. Software also sets the on/off mask of the domains while the chip runs. A wake-up event brings the chip back to normal operation.

Each deeper mode adds one step to a fixed entry chain:

- IDLE only stops the CPU clock.
- STOP freezes all clocks and then turns the PLL off.
- DEEP-STOP also switches every domain off and waits for the switch acknowledges.
- SLEEP also asserts the internal reset, cuts the main supply and waits for power-good to drop.

Exit runs the same chain backwards. It waits for power-good before releasing reset. It waits for the domain acknowledges to match the saved mask. It waits a programmable number of cycles for the PLL to lock before clocks are released.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the outputs are: cpu_clk_en=1, clk_freeze=0, pll_en=1, main_pwr_en=1, int_rst_n=1, busy=0 and cur_mode=0. dom_pwr_en equals the reset mask, which is all ones.
- R2: Mode codes are 0 NORMAL, 1 IDLE, 2 STOP, 3 DEEP-STOP and 4 SLEEP.
  - An IDLE request accepted in NORMAL gives cpu_clk_en=0 and cur_mode=1 one cycle later. PLL, freeze, supply, reset and domains are unchanged.
  - A wake event in IDLE returns to NORMAL on the next cycle.
- R3: Entry into STOP is a two-cycle sequence that leaves the domains as they were.
  - One cycle after the request, clk_freeze=1 and cpu_clk_en=0 while pll_en is still 1.
  - One cycle later, pll_en=0.
- R4: On wake from STOP, DEEP-STOP or SLEEP, pll_en rises first while clk_freeze stays high.
  - This lock phase lasts lock_cnt+1 cycles.
  - After it, the freeze is released and cpu_clk_en returns to 1 in the same cycle.
- R5: DEEP-STOP does everything STOP does, and adds the following.
  - After the PLL turns off, dom_pwr_en goes to 0. The sequence waits until dom_ack is all zero.
  - On wake, dom_pwr_en returns to the saved mask. The PLL stays off until dom_ack equals that mask.
- R6: SLEEP does everything DEEP-STOP does, and adds the following.
  - After the domains are off, int_rst_n drops, and then main_pwr_en drops.
  - On wake, main_pwr_en rises while int_rst_n stays low until pgood is sampled high. int_rst_n rises one cycle later.
- R7: A mode request is ignored unless the controller is in NORMAL. This covers requests in IDLE, during entry or exit, and in a low-power state. Requests for codes 0, 5, 6 and 7 are also ignored.
- R8: A domain mask write (dom_wr) in NORMAL sets dom_pwr_en on the next cycle. A write in any other state has no effect.
- R9: A wake event that arrives during an entry sequence is held. The controller leaves the low-power state as soon as the entry completes.
- R10: busy is 1 in every entry and exit step. It is 0 in NORMAL, IDLE and a settled low-power state. cur_mode shows the active mode code, or 0 in NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| dom_wr | input | 1 | Domain mask write strobe |
| dom_wdata | input | ND | New domain on/off mask |
| lock_cnt | input | LCW | PLL lock wait length in cycles, minus one |
| wake_evt | input | 1 | Wake-up event |
| dom_ack | input | ND | Domain switch acknowledges, 1 = powered |
| pgood | input | 1 | Main supply power-good |
| cpu_clk_en | output | 1 | CPU clock enable |
| clk_freeze | output | 1 | Global clock freeze |
| pll_en | output | 1 | PLL enable |
| main_pwr_en | output | 1 | Main supply switch enable |
| int_rst_n | output | 1 | Internal logic reset, active low |
| dom_pwr_en | output | ND | Domain switch enables |
| cur_mode | output | 3 | Active mode code |
| busy | output | 1 | Entry or exit sequence in progress |

## Verification
The hardest situations to reach are the waiting steps: a DEEP-STOP or SLEEP transition stalled on a slow acknowledge, and a wake event that arrives while an entry is still underway. The bench drives a small switch model that copies the enables onto dom_ack and pgood one cycle later. Two hold flags can freeze that model, which parks the controller in a waiting step for as long as the test needs. The bench then checks that nothing advances, releases the hold, and counts the cycles to the next output change. For the early wake, it fires the event while domain acknowledges are held back, then confirms the controller still returns to NORMAL by itself.

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl #(
  parameter int ND = 6,
  parameter int LCW = 16,
  parameter logic [ND-1:0] DOM_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_mode,
  input  logic          dom_wr,
  input  logic [ND-1:0] dom_wdata,
  input  logic [LCW-1:0] lock_cnt,
  input  logic          wake_evt,
  input  logic [ND-1:0] dom_ack,
  input  logic          pgood,
  output logic          cpu_clk_en,
  output logic          clk_freeze,
  output logic          pll_en,
  output logic          main_pwr_en,
  output logic          int_rst_n,
  output logic [ND-1:0] dom_pwr_en,
  output logic [2:0]    cur_mode,
  output logic          busy
);
  localparam logic [2:0] M_NORM = 3'd0, M_IDLE = 3'd1, M_STOP = 3'd2,
                         M_DEEP = 3'd3, M_SLEEP = 3'd4;

  typedef enum logic [3:0] {
    S_RUN, S_IDLE, S_FRZ, S_PLLOFF, S_DOMOFF, S_RSTON, S_PWROFF,
    S_LOW, S_PWRON, S_RSTOFF, S_DOMON, S_PLLON
  } st_t;

  st_t st, st_n;
  logic [2:0] tgt;
  logic [ND-1:0] dom_sw;
  logic [LCW-1:0] cnt;
  logic wk_pend;
  logic accept, entering, wake, dom_off;

  assign accept   = req_valid && st == S_RUN && req_mode >= M_IDLE && req_mode <= M_SLEEP;
  assign entering = st inside {S_FRZ, S_PLLOFF, S_DOMOFF, S_RSTON, S_PWROFF};
  assign wake     = wake_evt || wk_pend;

  always_comb begin
    st_n = st;
    case (st)
      S_RUN:    if (accept) st_n = (req_mode == M_IDLE) ? S_IDLE : S_FRZ;
      S_IDLE:   if (wake_evt) st_n = S_RUN;
      S_FRZ:    st_n = S_PLLOFF;
      S_PLLOFF: st_n = (tgt == M_STOP) ? S_LOW : S_DOMOFF;
      S_DOMOFF: if (dom_ack == '0) st_n = (tgt == M_DEEP) ? S_LOW : S_RSTON;
      S_RSTON:  st_n = S_PWROFF;
      S_PWROFF: if (!pgood) st_n = S_LOW;
      S_LOW:    if (wake) st_n = (tgt == M_SLEEP) ? S_PWRON :
                                 (tgt == M_DEEP)  ? S_DOMON : S_PLLON;
      S_PWRON:  if (pgood) st_n = S_RSTOFF;
      S_RSTOFF: st_n = S_DOMON;
      S_DOMON:  if (dom_ack == dom_sw) st_n = S_PLLON;
      S_PLLON:  if (cnt == '0) st_n = S_RUN;
      default:  st_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      tgt     <= M_NORM;
      dom_sw  <= DOM_RST;
      cnt     <= '0;
      wk_pend <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) tgt <= req_mode;
      if (dom_wr && st == S_RUN) dom_sw <= dom_wdata;
      if (st != S_PLLON) cnt <= lock_cnt;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      wk_pend <= entering ? (wk_pend || wake_evt) : 1'b0;
    end
  end

  assign dom_off = st inside {S_DOMOFF, S_RSTON, S_PWROFF, S_PWRON, S_RSTOFF} ||
                   (st == S_LOW && tgt != M_STOP);

  assign cpu_clk_en  = st == S_RUN;
  assign clk_freeze  = !(st inside {S_RUN, S_IDLE});
  assign pll_en      = st inside {S_RUN, S_IDLE, S_FRZ, S_PLLON};
  assign main_pwr_en = !(st == S_PWROFF || (st == S_LOW && tgt == M_SLEEP));
  assign int_rst_n   = !(st inside {S_RSTON, S_PWROFF, S_PWRON} ||
                         (st == S_LOW && tgt == M_SLEEP));
  assign dom_pwr_en  = dom_off ? '0 : dom_sw;
  assign cur_mode    = (st == S_RUN) ? M_NORM : tgt;
  assign busy        = !(st inside {S_RUN, S_IDLE, S_LOW});
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(parameter int ND = 6) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_clk_en,
  input logic          clk_freeze,
  input logic          pll_en,
  input logic          main_pwr_en,
  input logic          int_rst_n,
  input logic [ND-1:0] dom_pwr_en,
  input logic          pgood,
  input logic [2:0]    cur_mode,
  input logic          busy
);
  AST_FREEZE_STOPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    clk_freeze |-> !cpu_clk_en);                                   // R3
  AST_PLL_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> clk_freeze);                                       // R3
  AST_THAW_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_freeze) |-> $past(pll_en));                          // R4
  AST_CUT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pwr_en |-> (!int_rst_n && dom_pwr_en == '0));            // R6
  AST_RELEASE_ON_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst_n) |-> $past(pgood));                            // R6
  AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_mode));                  // R7
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ND(ND)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_clk_en), .clk_freeze(clk_freeze),
  .pll_en(pll_en), .main_pwr_en(main_pwr_en), .int_rst_n(int_rst_n),
  .dom_pwr_en(dom_pwr_en), .pgood(pgood), .cur_mode(cur_mode), .busy(busy));

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int ND = 6;
  localparam int LCW = 16;
  localparam logic [ND-1:0] MASK = 6'b101010;
  localparam int LOCK = 5;
  // {mode, cpu, freeze, pll, main, rst_n, domains_off}
  localparam logic [8:0] VEC [6] = '{
    9'b001_0_0_1_1_1_0,
    9'b010_0_1_0_1_1_0,
    9'b011_0_1_0_1_1_1,
    9'b100_0_1_0_0_0_1,
    9'b000_1_0_1_1_1_0,
    9'b110_1_0_1_1_1_0
  };

  logic clk = 0, rst_n = 0, req_valid = 0, dom_wr = 0, wake_evt = 0, pgood = 1;
  logic [2:0] req_mode = 0;
  logic [ND-1:0] dom_wdata = 0, dom_ack = '1, dom_pwr_en;
  logic [LCW-1:0] lock_cnt = LOCK;
  logic cpu_clk_en, clk_freeze, pll_en, main_pwr_en, int_rst_n, busy;
  logic [2:0] cur_mode;
  logic hold_dom = 0, hold_pg = 0, done = 0;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!hold_dom) dom_ack <= dom_pwr_en;
    if (!hold_pg) pgood <= main_pwr_en;
  end

  pwr_mode_ctrl #(.ND(ND), .LCW(LCW)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .dom_wr(dom_wr), .dom_wdata(dom_wdata), .lock_cnt(lock_cnt),
    .wake_evt(wake_evt), .dom_ack(dom_ack), .pgood(pgood),
    .cpu_clk_en(cpu_clk_en), .clk_freeze(clk_freeze), .pll_en(pll_en),
    .main_pwr_en(main_pwr_en), .int_rst_n(int_rst_n), .dom_pwr_en(dom_pwr_en),
    .cur_mode(cur_mode), .busy(busy));

  function automatic logic [14:0] obs();
    return {cpu_clk_en, clk_freeze, pll_en, main_pwr_en, int_rst_n, busy, cur_mode, dom_pwr_en};
  endfunction

  function automatic logic [14:0] mk(input logic c, f, p, m, r, b, input logic [2:0] cm,
                                     input logic [ND-1:0] d);
    return {c, f, p, m, r, b, cm, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic request(input logic [2:0] m);
    req_valid = 1; req_mode = m; tick(); req_valid = 0;
  endtask

  task automatic wake();
    wake_evt = 1; tick(); wake_evt = 0;
  endtask

  task automatic settle();
    for (int n = 0; n < 500 && busy; n++) tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int n;
    tick(); tick();
    // R1 reset state
    check("R1 reset", obs(), mk(1, 0, 1, 1, 1, 0, 0, '1));
    rst_n = 1; tick();

    // R8 mask write in NORMAL
    dom_wr = 1; dom_wdata = MASK; tick(); dom_wr = 0;
    check("R8 write in NORMAL", dom_pwr_en, MASK);
    tick();

    // Table walk: R2 R3 R5 R6 R7
    foreach (VEC[i]) begin
      logic [2:0] m;
      logic [2:0] cm;
      m = VEC[i][8:6];
      cm = (m >= 1 && m <= 4) ? m : 3'd0;
      request(m);
      settle();
      check($sformatf("R2/R3/R5/R6/R7 low state mode %0d", m), obs(),
            mk(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], 0, cm,
               VEC[i][0] ? '0 : MASK));
      wake();
      settle();
      check($sformatf("R2/R4 back to NORMAL from mode %0d", m), obs(),
            mk(1, 0, 1, 1, 1, 0, 0, MASK));
      tick();
    end

    // R3 R10 STOP entry timing, R4 lock window
    request(2);
    check("R3 freeze first", obs(), mk(0, 1, 1, 1, 1, 1, 2, MASK));
    tick();
    check("R3 R10 PLL off, busy", obs(), mk(0, 1, 0, 1, 1, 1, 2, MASK));
    tick();
    check("R10 settled STOP not busy", obs(), mk(0, 1, 0, 1, 1, 0, 2, MASK));
    wake();
    check("R4 PLL first, still frozen", {pll_en, clk_freeze}, 2'b11);
    n = 0;
    while (clk_freeze && n < 100) begin n++; tick(); end
    check("R4 lock window length", n, LOCK + 1);
    check("R4 CPU clock back", cpu_clk_en, 1);
    tick();

    // R7 request ignored during entry
    request(2);
    request(4);
    settle();
    check("R7 second request ignored", {cur_mode, main_pwr_en, int_rst_n}, {3'd2, 2'b11});
    wake(); settle(); tick();

    // R7 request ignored in IDLE, R8 write ignored in IDLE
    request(1);
    request(2);
    check("R7 request in IDLE ignored", {clk_freeze, cur_mode}, {1'b0, 3'd1});
    dom_wr = 1; dom_wdata = 6'b000001; tick(); dom_wr = 0;
    check("R8 write in IDLE ignored", dom_pwr_en, MASK);
    wake(); settle();
    check("R8 mask kept after IDLE", dom_pwr_en, MASK);
    tick();

    // R5 DEEP-STOP waits on acknowledges both ways
    hold_dom = 1;
    request(3);
    repeat (6) tick();
    check("R5 entry waits for acks", obs(), mk(0, 1, 0, 1, 1, 1, 3, '0));
    hold_dom = 0;
    settle();
    check("R5 entry done", busy, 0);
    hold_dom = 1;
    wake();
    repeat (6) tick();
    check("R5 exit waits for acks", obs(), mk(0, 1, 0, 1, 1, 1, 3, MASK));
    hold_dom = 0;
    settle();
    check("R5 restored", obs(), mk(1, 0, 1, 1, 1, 0, 0, MASK));
    tick();

    // R6 SLEEP waits for power-good before reset release
    request(4);
    settle();
    hold_pg = 1;
    wake();
    repeat (5) tick();
    check("R6 held in reset without pgood", {main_pwr_en, int_rst_n, busy}, 3'b101);
    hold_pg = 0;
    tick();
    check("R6 reset held until pgood sampled", int_rst_n, 0);
    tick();
    check("R6 reset released", int_rst_n, 1);
    settle();
    check("R6 back to NORMAL", obs(), mk(1, 0, 1, 1, 1, 0, 0, MASK));
    tick();

    // R9 early wake held during entry
    hold_dom = 1;
    request(3);
    tick(); tick();
    wake();
    hold_dom = 0;
    n = 0;
    while ((busy || cur_mode != 0) && n < 200) begin n++; tick(); end
    check("R9 early wake returns", obs(), mk(1, 0, 1, 1, 1, 0, 0, MASK));

    done = 1;
    finish_run();
  end
endmodule